// File: doc/BRIEF.md
# Bus Access Match Comparator

This block watches a processor's internal memory bus. It raises a match pulse when one access meets a set of programmed conditions. An access must hit the programmed address exactly. Optional checks then qualify it on read/write direction, on access size (byte or word) and on the 16-bit data contents. The data check has a mask bit for each data bit and a polarity control. The polarity selects whether the check fires on equality or on difference.

Software loads the settings through a small register write port. Select 0 holds the reference address. Select 1 holds the data reference, with the high byte in bits 15:8 and the low byte in bits 7:0. Select 2 holds the data mask in the same byte layout. Select 3 holds the control bits:

- bit 0: global enable.
- bit 1: direction-check enable.
- bit 2: the required direction, where 1 means write.
- bit 3: size-check enable.
- bit 4: the required size, where 1 means byte and 0 means word.
- bit 5: difference mode.

On the bus, `bus_byte` is 1 for a byte access. On a word access, `bus_data[15:8]` carries the byte at the access address and `bus_data[7:0]` carries the byte at the next address. On a byte access, the byte sits on `bus_data[15:8]`.

Top module: `bus_match_cmp`

## Requirements
- R1: A match requires `bus_addr` to equal the reference address exactly. A word access at the reference address minus one never matches, even though it covers the reference address.
- R2: When size checking is on (control bit 3), control bit 4 at 0 allows only word accesses and at 1 allows only byte accesses. When size checking is off, the access size is ignored.
- R3: When direction checking is on (control bit 1), the access must have `bus_write` equal to control bit 2.
- R4: On a word access, `bus_data[15:8]` is compared with reference bits 15:8 and `bus_data[7:0]` is compared with reference bits 7:0.
- R5: A mask bit of 0 removes the matching data bit from the comparison.
- R6: With all mask bits 0 and difference mode off, the data is not compared.
- R7: With difference mode on (control bit 5), the data check passes only when at least one unmasked bit differs from the reference.
- R8: A byte access with size checking on compares only bits 15:8, and mask bits 7:0 are treated as 0. With size checking off, mask bits 7:0 still apply to `bus_data[7:0]`.
- R9: With difference mode on and all mask bits 0, the data check passes.
- R10: `match_o` is high for exactly the cycle after a qualifying access with `bus_valid` high. It stays 0 while the global enable (control bit 0) is 0.
- R11: Reset clears all settings and `match_o`. A register write affects matching only from the next clock edge, so an access in the same cycle as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 data reference, 2 mask, 3 control |
| cfg_wdata | input | 16 | Register write data |
| bus_valid | input | 1 | Bus access valid |
| bus_addr | input | AW | Access address |
| bus_write | input | 1 | 1 for a write access |
| bus_byte | input | 1 | 1 for a byte access, 0 for a word access |
| bus_data | input | 16 | Data lanes |
| match_o | output | 1 | Registered match pulse |

## Verification
The assertions take for granted that the bus inputs are known whenever `bus_valid` is high. They also assume that a bus access and a register write in the same cycle are judged against the settings held before that edge. The stimulus changes inputs only on falling edges. It drives every field to a known value on each cycle, including idle ones. One case deliberately combines a control write with an access to exercise the old-settings rule.

// File: rtl/bus_match_cmp.sv
module bus_match_cmp #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [15:0]   cfg_wdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_write,
  input  logic          bus_byte,
  input  logic [DW-1:0] bus_data,
  output logic          match_o
);
  localparam int HB = DW / 2;

  logic [AW-1:0] ref_addr;
  logic [DW-1:0] ref_data, ref_mask;
  logic [5:0]    ctl;

  wire en       = ctl[0];
  wire dir_chk  = ctl[1];
  wire dir_val  = ctl[2];
  wire sz_chk   = ctl[3];
  wire sz_byte  = ctl[4];
  wire diff_md  = ctl[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_addr <= '0;
      ref_data <= '0;
      ref_mask <= '0;
      ctl      <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: ref_addr <= cfg_wdata[AW-1:0];
        2'd1: ref_data <= cfg_wdata[DW-1:0];
        2'd2: ref_mask <= cfg_wdata[DW-1:0];
        default: ctl   <= cfg_wdata[5:0];
      endcase
    end
  end

  wire [HB-1:0] lo_mask  = (bus_byte && sz_chk) ? '0 : ref_mask[HB-1:0];
  wire [DW-1:0] eff_mask = {ref_mask[DW-1:HB], lo_mask};
  wire [DW-1:0] miss     = (bus_data ^ ref_data) & eff_mask;

  wire data_ok = diff_md ? ((eff_mask == '0) || (miss != '0)) : (miss == '0);
  wire size_ok = !sz_chk || (bus_byte == sz_byte);
  wire dir_ok  = !dir_chk || (bus_write == dir_val);
  wire hit     = en && bus_valid && (bus_addr == ref_addr) && size_ok && dir_ok && data_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_o <= 1'b0;
    else        match_o <= hit;
  end
endmodule

module bus_match_cmp_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          match_o,
  input logic          bus_valid,
  input logic [AW-1:0] bus_addr,
  input logic          bus_write,
  input logic          bus_byte,
  input logic [AW-1:0] ref_addr,
  input logic [5:0]    ctl
);
  a_r10_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(bus_valid));
  a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl[0]) |-> !match_o);
  a_r1_exact_addr: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(bus_addr) == $past(ref_addr));
  a_r3_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && $past(ctl[1])) |-> $past(bus_write) == $past(ctl[2]));
  a_r2_size: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && $past(ctl[3])) |-> $past(bus_byte) == $past(ctl[4]));
  always_comb begin
    if (!rst_n) a_r11_reset_clear: assert (!match_o);
  end
endmodule

bind bus_match_cmp bus_match_cmp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .match_o(match_o), .bus_valid(bus_valid),
  .bus_addr(bus_addr), .bus_write(bus_write), .bus_byte(bus_byte),
  .ref_addr(ref_addr), .ctl(ctl)
);

// File: tb/bus_match_cmp_tb.sv
module bus_match_cmp_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic bus_valid = 0, bus_write = 0, bus_byte = 0;
  logic [15:0] bus_addr = 0, bus_data = 0;
  logic match_o;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R11";

  logic [15:0] m_addr, m_data, m_mask;
  logic [5:0]  m_ctl;
  bit exp_next;

  always #5 clk = ~clk;

  bus_match_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_byte(bus_byte), .bus_data(bus_data),
    .match_o(match_o)
  );

  function automatic bit predict();
    int used = 0, differ = 0;
    if (!m_ctl[0] || !bus_valid) return 0;
    if (bus_addr != m_addr) return 0;
    if (m_ctl[1] && (bus_write != m_ctl[2])) return 0;
    if (m_ctl[3] && (bus_byte != m_ctl[4])) return 0;
    for (int i = 0; i < 16; i++) begin
      bit take = m_mask[i];
      if (i < 8 && bus_byte && m_ctl[3]) take = 0;
      if (take) begin
        used++;
        if (bus_data[i] != m_data[i]) differ++;
      end
    end
    if (m_ctl[5]) return (used == 0) || (differ > 0);
    return differ == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr <= 0; m_data <= 0; m_mask <= 0; m_ctl <= 0;
      exp_next <= 0;
    end else begin
      exp_next <= predict();
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_addr <= cfg_wdata;
          2'd1: m_data <= cfg_wdata;
          2'd2: m_mask <= cfg_wdata;
          default: m_ctl <= cfg_wdata[5:0];
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (match_o !== exp_next) begin
        failures++;
        $display("FAIL %s match_o actual=%b expected=%b", tag, match_o, exp_next);
      end
    end
  end

  task automatic step(bit we, logic [1:0] sel, logic [15:0] wd,
                      bit v, logic [15:0] a, bit w, bit b, logic [15:0] d);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    bus_valid = v; bus_addr = a; bus_write = w; bus_byte = b; bus_data = d;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] wd);
    step(1, sel, wd, 0, 0, 0, 0, 0);
  endtask

  task automatic acc(logic [15:0] a, bit w, bit b, logic [15:0] d);
    step(0, 0, 0, 1, a, w, b, d);
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R11";
    if (match_o !== 1'b0) begin
      failures++; $display("FAIL R11 reset match_o actual=%b expected=0", match_o);
    end
    checks++;
    rst_n = 1;
    @(negedge clk);
    acc(16'h0000, 0, 0, 16'h0000);
    tag = "R10"; wr(0, 16'h1234); wr(1, 16'hA55A); wr(2, 16'hFFFF);
    acc(16'h1234, 0, 0, 16'hA55A);
    tag = "R10"; step(0, 0, 0, 0, 16'h1234, 0, 0, 16'hA55A); step(0, 0, 0, 0, 0, 0, 0, 0);
    wr(3, 16'h0001);
    tag = "R4"; acc(16'h1234, 0, 0, 16'hA55A); acc(16'h1234, 0, 0, 16'h5AA5);
    acc(16'h1234, 0, 0, 16'hA55B); acc(16'h1234, 0, 0, 16'hA45A);
    tag = "R1"; acc(16'h1233, 0, 0, 16'hA55A); acc(16'h1233, 0, 0, 16'h00A5);
    acc(16'h1235, 0, 0, 16'hA55A);
    tag = "R10"; step(0, 0, 0, 1, 16'h1234, 0, 0, 16'hA55A);
    step(0, 0, 0, 1, 16'h1234, 0, 0, 16'hA55A); step(0, 0, 0, 0, 0, 0, 0, 0);
    tag = "R5"; wr(2, 16'hF00F);
    acc(16'h1234, 0, 0, 16'hA33A); acc(16'h1234, 0, 0, 16'hB33A); acc(16'h1234, 0, 0, 16'hA33B);
    tag = "R6"; wr(2, 16'h0000);
    acc(16'h1234, 0, 0, 16'h0000); acc(16'h1234, 1, 1, 16'h7777);
    tag = "R3"; wr(2, 16'hFFFF); wr(3, 16'h0007);
    acc(16'h1234, 1, 0, 16'hA55A); acc(16'h1234, 0, 0, 16'hA55A);
    wr(3, 16'h0003); acc(16'h1234, 0, 0, 16'hA55A); acc(16'h1234, 1, 0, 16'hA55A);
    tag = "R2"; wr(3, 16'h0019);
    acc(16'h1234, 0, 0, 16'hA55A); acc(16'h1234, 0, 1, 16'hA500);
    wr(3, 16'h0009); acc(16'h1234, 0, 1, 16'hA55A); acc(16'h1234, 0, 0, 16'hA55A);
    tag = "R8"; wr(3, 16'h0019);
    acc(16'h1234, 0, 1, 16'hA5FF); acc(16'h1234, 0, 1, 16'hA4FF);
    wr(3, 16'h0001); acc(16'h1234, 0, 1, 16'hA500); acc(16'h1234, 0, 1, 16'hA55A);
    tag = "R7"; wr(3, 16'h0021);
    acc(16'h1234, 0, 0, 16'hA55A); acc(16'h1234, 0, 0, 16'hA55B); acc(16'h1234, 0, 0, 16'h255A);
    wr(2, 16'hFF00); acc(16'h1234, 0, 0, 16'hA500); acc(16'h1234, 0, 0, 16'hA65A);
    tag = "R9"; wr(2, 16'h0000);
    acc(16'h1234, 0, 0, 16'hA55A); acc(16'h1235, 0, 0, 16'hA55A);
    tag = "R11"; wr(2, 16'hFFFF); wr(3, 16'h0001);
    step(1, 3, 16'h0000, 1, 16'h1234, 0, 0, 16'hA55A); step(0, 0, 0, 0, 0, 0, 0, 0);
    acc(16'h1234, 0, 0, 16'hA55A);
    step(1, 3, 16'h0001, 1, 16'h1234, 0, 0, 16'hA55A); step(0, 0, 0, 0, 0, 0, 0, 0);
    acc(16'h1234, 0, 0, 16'hA55A);
    tag = "R10"; wr(3, 16'h0000); acc(16'h1234, 0, 0, 16'hA55A);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule